// File: doc/BRIEF.md
# Pin I/O port with set and clear alias registers

This block is a 32-pin general-purpose I/O port attached to a simple single-cycle register bus. Software drives output values and output enables and reads back the pin states. It can also turn any pin into an interrupt source. Every writable register sits at a base word. Two neighbouring words act on the same register: one ORs ones in and the other removes them. Software can therefore change single pins without a read-modify-write.

Inputs pass through a synchroniser before any other logic sees them. For each pin, two configuration bits choose the trigger. One bit picks edge or level sensitivity and the other picks polarity. This gives four triggers: rising edge, falling edge, high level and low level. A trigger only counts when the pin is routed to the interrupt logic. A hit sets a sticky status bit, and only a write of ones to the clear word of the status register removes it. The masked status bits are ORed into one port interrupt line.

Register byte addresses: bits [6:4] select the register and bits [3:2] select the access kind. Registers: 0 output data, 1 output enable, 2 input data, 3 interrupt routing, 4 interrupt enable, 5 level/edge select, 6 polarity, 7 status. Access kinds: 0 write, 1 set, 2 clear, 3 no write.

Top module: `gpio_alias_port`

## Requirements
- R1: After reset, every register reads zero, and pad_out, pad_oe and irq are all zero.
- R2: For output data, output enable, routing, enable, level and polarity, a write at kind 0 replaces the register, kind 1 ORs bus_wdata into it, and kind 2 clears the bits where bus_wdata is 1. A write at kind 3 changes nothing. Each write takes effect at the next clock edge.
- R3: A read at any access kind of a register returns that register's current value, combinationally from bus_addr.
- R4: pad_out equals the output-data register and pad_oe equals the output-enable register (1 = drive).
- R5: The input-data register returns pad_in after two clock edges of synchronisation. Writes at any of its access kinds have no effect.
- R6: With level bit 0, polarity 1 detects a rising edge and polarity 0 detects a falling edge of the synchronised input. The status bit is set on the clock edge after the input-data register shows the new value.
- R7: With level bit 1, the status bit is set on every clock edge on which the synchronised input equals the polarity bit. Clearing it therefore has no lasting effect while that level holds.
- R8: A pin whose routing bit is 0 never sets its status bit.
- R9: Status bits are sticky. They are cleared only by a write at kind 2 of the status register, for the bits written as 1. Writes at kind 0 or kind 1 of the status register are ignored.
- R10: When a trigger and a clear of the same status bit fall on the same edge, the bit ends up set.
- R11: irq is 1 exactly when the bitwise AND of the status and enable registers is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 7 | Byte address: register in [6:4], access kind in [3:2] |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| pad_in | input | 32 | Asynchronous pin inputs |
| pad_out | output | 32 | Pin output values |
| pad_oe | output | 32 | Pin output enables |
| irq | output | 1 | Combined port interrupt |

## Verification
A corrupted configuration register shows at once on bus_rdata when its address is read, and on pad_out or pad_oe for the data and enable registers. A synchroniser stage that is too short or too long moves the input-data readback, and every status set, by one cycle. Comparing every cycle exposes that. A wrong trigger decode, routing gate or clear priority shows up as a status bit that differs on the first edge after the stimulus. It also moves irq in that same cycle.

// File: rtl/gpio_alias_pkg.sv
package gpio_alias_pkg;
    localparam int ADDR_W = 7;

    typedef enum logic [1:0] {
        OP_WRITE = 2'd0,
        OP_SET   = 2'd1,
        OP_CLEAR = 2'd2,
        OP_NONE  = 2'd3
    } alias_op_e;

    typedef enum logic [2:0] {
        RI_DOUT  = 3'd0,
        RI_OE    = 3'd1,
        RI_DIN   = 3'd2,
        RI_ROUTE = 3'd3,
        RI_IEN   = 3'd4,
        RI_LVL   = 3'd5,
        RI_POL   = 3'd6,
        RI_STAT  = 3'd7
    } reg_idx_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;
    logic [STAGES-1:0][WIDTH-1:0] stage_d;

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q <= '0;
        else        stage_q <= stage_d;
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_alias_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  din,
    input  logic [NPINS-1:0]  stat,
    output logic [NPINS-1:0]  dout,
    output logic [NPINS-1:0]  oe,
    output logic [NPINS-1:0]  route,
    output logic [NPINS-1:0]  ien,
    output logic [NPINS-1:0]  lvl,
    output logic [NPINS-1:0]  pol,
    output logic [NPINS-1:0]  stat_clr
);
    typedef struct packed {
        logic [NPINS-1:0] dout;
        logic [NPINS-1:0] oe;
        logic [NPINS-1:0] route;
        logic [NPINS-1:0] ien;
        logic [NPINS-1:0] lvl;
        logic [NPINS-1:0] pol;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    reg_idx_e  idx;
    alias_op_e op;

    assign idx = reg_idx_e'(bus_addr[6:4]);
    assign op  = alias_op_e'(bus_addr[3:2]);

    function automatic logic [NPINS-1:0] apply_op(
        input logic [NPINS-1:0] cur,
        input alias_op_e        kind,
        input logic [NPINS-1:0] val
    );
        case (kind)
            OP_WRITE: apply_op = val;
            OP_SET:   apply_op = cur | val;
            OP_CLEAR: apply_op = cur & ~val;
            default:  apply_op = cur;
        endcase
    endfunction

    always_comb begin
        cfg_d    = cfg_q;
        stat_clr = '0;
        if (bus_wr) begin
            case (idx)
                RI_DOUT:  cfg_d.dout  = apply_op(cfg_q.dout,  op, bus_wdata);
                RI_OE:    cfg_d.oe    = apply_op(cfg_q.oe,    op, bus_wdata);
                RI_ROUTE: cfg_d.route = apply_op(cfg_q.route, op, bus_wdata);
                RI_IEN:   cfg_d.ien   = apply_op(cfg_q.ien,   op, bus_wdata);
                RI_LVL:   cfg_d.lvl   = apply_op(cfg_q.lvl,   op, bus_wdata);
                RI_POL:   cfg_d.pol   = apply_op(cfg_q.pol,   op, bus_wdata);
                RI_STAT:  if (op == OP_CLEAR) stat_clr = bus_wdata;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        case (idx)
            RI_DOUT:  bus_rdata = cfg_q.dout;
            RI_OE:    bus_rdata = cfg_q.oe;
            RI_DIN:   bus_rdata = din;
            RI_ROUTE: bus_rdata = cfg_q.route;
            RI_IEN:   bus_rdata = cfg_q.ien;
            RI_LVL:   bus_rdata = cfg_q.lvl;
            RI_POL:   bus_rdata = cfg_q.pol;
            default:  bus_rdata = stat;
        endcase
    end

    assign dout  = cfg_q.dout;
    assign oe    = cfg_q.oe;
    assign route = cfg_q.route;
    assign ien   = cfg_q.ien;
    assign lvl   = cfg_q.lvl;
    assign pol   = cfg_q.pol;

    assert_set_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[6:2] == {RI_DOUT, OP_SET})
        |=> ((dout & $past(bus_wdata)) == $past(bus_wdata)));

    assert_clear_alias_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[6:2] == {RI_OE, OP_CLEAR})
        |=> ((oe & $past(bus_wdata)) == '0));

    assert_none_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[3:2] == OP_NONE) |=> $stable(cfg_q));
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] din,
    input  logic [NPINS-1:0] route,
    input  logic [NPINS-1:0] lvl,
    input  logic [NPINS-1:0] pol,
    input  logic [NPINS-1:0] stat_clr,
    output logic [NPINS-1:0] stat
);
    typedef struct packed {
        logic [NPINS-1:0] prev;
        logic [NPINS-1:0] stat;
    } st_t;

    st_t st_d, st_q;
    logic [NPINS-1:0] hit;

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic edge_hit, level_hit;
        assign edge_hit  = pol[p] ? (din[p] & ~st_q.prev[p]) : (~din[p] & st_q.prev[p]);
        assign level_hit = (din[p] == pol[p]);
        assign hit[p]    = route[p] & (lvl[p] ? level_hit : edge_hit);
    end

    always_comb begin
        st_d.prev = din;
        st_d.stat = (st_q.stat & ~stat_clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign stat = st_q.stat;

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((~stat & $past(stat) & ~$past(stat_clr)) == '0));

    assert_route_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((stat & ~$past(stat) & ~$past(route)) == '0));

    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(hit) & ~stat) == '0));
endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port
    import gpio_alias_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);
    logic [NPINS-1:0] din, stat, route, ien, lvl, pol, stat_clr;

    gpio_in_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(din)
    );

    gpio_regfile #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .din(din), .stat(stat),
        .dout(pad_out), .oe(pad_oe), .route(route), .ien(ien), .lvl(lvl),
        .pol(pol), .stat_clr(stat_clr)
    );

    gpio_irq_unit #(.NPINS(NPINS)) u_irq (
        .clk(clk), .rst_n(rst_n), .din(din), .route(route), .lvl(lvl),
        .pol(pol), .stat_clr(stat_clr), .stat(stat)
    );

    assign irq = |(stat & ien);

    assert_irq_needs_en_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == '0) |-> !irq);
endmodule

// File: tb/gpio_alias_port_tb_top.sv
`timescale 1ns/100ps
module gpio_alias_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out, pad_oe;
    logic        irq;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    gpio_alias_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    // Behavioural reference: cfg[k] holds register k, stat and a pad history queue
    logic [31:0] cfg [8];
    logic [31:0] m_stat;
    logic [31:0] hist [$];   // hist[0] newest sample taken at an edge

    function automatic logic [31:0] m_din();
        return (hist.size() >= 2) ? hist[1] : 32'h0;
    endfunction
    function automatic logic [31:0] m_prev();
        return (hist.size() >= 3) ? hist[2] : 32'h0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < 8; k++) cfg[k] = '0;
            m_stat = '0;
            hist = {};
        end else begin
            logic [31:0] trig, clr, cur, pv;
            int k, kind;
            trig = '0;
            cur = m_din();
            pv  = m_prev();
            for (int p = 0; p < 32; p++) begin
                if (cfg[3][p]) begin
                    if (cfg[5][p]) trig[p] = (cur[p] == cfg[6][p]);
                    else if (cfg[6][p]) trig[p] = cur[p] && !pv[p];
                    else trig[p] = !cur[p] && pv[p];
                end
            end
            k = int'(bus_addr[6:4]);
            kind = int'(bus_addr[3:2]);
            clr = (bus_wr && k == 7 && kind == 2) ? bus_wdata : 32'h0;
            m_stat = (m_stat & ~clr) | trig;
            if (bus_wr && k != 2 && k != 7) begin
                if (kind == 0) cfg[k] = bus_wdata;
                else if (kind == 1) cfg[k] = cfg[k] | bus_wdata;
                else if (kind == 2) cfg[k] = cfg[k] & ~bus_wdata;
            end
            hist.push_front(pad_in);
            if (hist.size() > 3) void'(hist.pop_back());
        end
    end

    function automatic logic [31:0] m_read(input logic [6:0] a);
        int k = int'(a[6:4]);
        if (k == 2) return m_din();
        if (k == 7) return m_stat;
        return cfg[k];
    endfunction

    task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h t=%0t", cur_req, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            vectors++;
            cmp("bus_rdata", bus_rdata, m_read(bus_addr));
            cmp("pad_out", pad_out, cfg[0]);
            cmp("pad_oe", pad_oe, cfg[1]);
            cmp("irq", {31'b0, irq}, {31'b0, |(m_stat & cfg[4])});
        end
    end

    task automatic wr(input int k, input int kind, input logic [31:0] d);
        @(negedge clk); #1;
        bus_wr = 1'b1; bus_addr = {3'(k), 2'(kind), 2'b00}; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input int k, input int kind);
        @(negedge clk); #1;
        bus_addr = {3'(k), 2'(kind), 2'b00};
    endtask

    task automatic pins(input logic [31:0] v, input int hold);
        @(negedge clk); #1;
        pad_in = v;
        repeat (hold) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        // R1: every register zero after reset
        cur_req = "R1";
        for (int k = 0; k < 8; k++) rd(k, 0);
        // R2 and R4: write, set, clear and no-write kinds
        cur_req = "R2";
        wr(0, 0, 32'hA5A5_A5A5);
        wr(0, 1, 32'h0000_000F);
        wr(0, 2, 32'hA000_00A0);
        wr(0, 3, 32'hFFFF_FFFF);
        wr(1, 0, 32'h0F0F_0000);
        wr(1, 1, 32'h0000_00FF);
        wr(1, 2, 32'h0F00_0000);
        cur_req = "R4";
        rd(0, 0); rd(1, 0);
        // R3: aliases read back the base value
        cur_req = "R3";
        for (int a = 0; a < 4; a++) begin rd(0, a); rd(1, a); end
        // R5: input data through two stages, writes ignored
        cur_req = "R5";
        rd(2, 0);
        pins(32'h1234_5678, 4);
        wr(2, 0, 32'hFFFF_FFFF);
        wr(2, 1, 32'hFFFF_FFFF);
        wr(2, 2, 32'hFFFF_FFFF);
        rd(2, 0);
        pins(32'h0, 4);
        // R6: edge triggers, upper half rising, lower half falling
        cur_req = "R6";
        wr(3, 0, 32'hFFFF_FFFF);
        wr(4, 0, 32'hFFFF_FFFF);
        wr(6, 0, 32'hFFFF_0000);
        rd(7, 0);
        pins(32'hFFFF_FFFF, 5);
        wr(7, 2, 32'hFFFF_FFFF);
        pins(32'h0000_0000, 5);
        // R9: sticky, base and set writes to status ignored
        cur_req = "R9";
        wr(7, 0, 32'h0);
        wr(7, 1, 32'hFFFF_FFFF);
        wr(7, 2, 32'h0000_FF00);
        wr(7, 2, 32'hFFFF_FFFF);
        // R8: unrouted pins never latch
        cur_req = "R8";
        wr(3, 0, 32'h0000_00FF);
        pins(32'hFFFF_FFFF, 5);
        pins(32'h0, 5);
        wr(7, 2, 32'hFFFF_FFFF);
        // R7: level triggers keep re-setting
        cur_req = "R7";
        wr(3, 0, 32'hFFFF_FFFF);
        wr(5, 0, 32'hFFFF_FFFF);
        wr(6, 0, 32'h00FF_00FF);
        pins(32'h00F0_0F00, 4);
        wr(7, 2, 32'hFFFF_FFFF);
        rd(7, 0);
        pins(32'h00F0_0F00, 3);
        // R10: clear on the same edge as a trigger
        cur_req = "R10";
        wr(7, 2, 32'h00F0_F000);
        rd(7, 0);
        // R11: interrupt follows status and enable
        cur_req = "R11";
        wr(4, 0, 32'h0);
        wr(4, 1, 32'h0F00_0000);
        wr(5, 0, 32'h0);
        wr(7, 2, 32'hFFFF_FFFF);
        wr(4, 0, 32'h0000_0001);
        pins(32'h0000_0001, 5);
        wr(4, 2, 32'h0000_0001);
        wr(4, 1, 32'h0000_0001);
        wr(7, 2, 32'h0000_0001);
        pins(32'h0, 5);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL %s watchdog expired: actual=%0d expected<=20000", cur_req, cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end
endmodule